// File: doc/BRIEF.md
# Bus breakpoint comparator unit

This unit watches two on-chip buses, the main processor bus and the coprocessor bus, and raises breakpoint requests when an access matches a configured condition. Each bus presents a 23-bit address, 16-bit data, a write flag and a valid strobe. Four comparators are grouped into two pairs. The first comparator of each pair (index 0 and 2) compares the address and the data under a bit mask. The second comparator (index 1 and 3) compares the address only.

Each pair runs in one of several modes. In the single-match modes every comparator reports on its own. In the range modes the pair reports accesses whose address lies inside, or outside, an inclusive window. Each comparator is configured to issue a force request or a tag request. A force request is raised one cycle after the access. A tag request is held pending until the processor reports that the matching address reaches execution. A pipeline flush discards the pending request.

The watched buses are observed only. The unit never stalls them, so it exerts no back-pressure. All configuration pins are plain static levels.

Top module: `bkpt_watch_unit`

## Requirements
- R1: After reset, `force_hit`, `tag_hit` and `bkpt_req` are 0 and no tag request is pending. An execute report before any access therefore fires nothing.
- R2: In a single-match mode, comparator 0 (or 2) matches a qualified access when the address equals its reference and `((data ^ cfg_data) & cfg_mask) == 0`. A mask bit of 1 means that data bit must match; a mask bit of 0 means that bit is ignored. Pair p uses field [16p +: 16].
- R3: Comparators 1 and 3 match on address equality alone; the bus data has no effect on them.
- R4: `cfg_bus[i]` = 0 makes comparator i watch the processor bus, and 1 makes it watch the coprocessor bus. Activity on the other bus has no effect on that comparator.
- R5: A comparator whose `cfg_en[i]` bit is 0 never matches.
- R6: When `cfg_rwq[i]` is 1, an access qualifies only if its write flag equals `cfg_rwv[i]`. When `cfg_rwq[i]` is 0, reads and writes both qualify.
- R7: Pair mode 1 (inside) reports on the first comparator when the address satisfies lo <= address <= hi. Here lo is the first comparator's reference and hi is the second comparator's reference. The range uses the first comparator's bus, enable and read/write qualifier, and ignores data. The second comparator reports nothing in this mode.
- R8: Pair mode 2 (outside) reports on the first comparator when address < lo or address > hi, under the same rules as R7. Mode 0 and mode 3 are both single-match. The mode of pair p is `cfg_mode[2p +: 2]`.
- R9: A match on comparator i with `cfg_kind[i]` = 1 (force) sets `force_hit[i]` for exactly the one cycle that follows the access.
- R10: A match with `cfg_kind[i]` = 0 (tag) captures the accessed address and raises nothing at once. The first later cycle with `exec_vld` = 1 and `exec_addr` equal to the captured address sets `tag_hit[i]` in the following cycle and clears the pending request.
- R11: `flush` clears every pending tag request. An execute report in the same cycle as `flush` fires nothing. A match in the same cycle as `flush` is still captured.
- R12: `bkpt_req` is 1 in exactly the cycles where any bit of `force_hit` or `tag_hit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_vld | input | 1 | Processor bus access valid |
| cpu_addr | input | 23 | Processor bus address |
| cpu_data | input | 16 | Processor bus data |
| cpu_wr | input | 1 | Processor bus write flag (1 = write) |
| cop_vld | input | 1 | Coprocessor bus access valid |
| cop_addr | input | 23 | Coprocessor bus address |
| cop_data | input | 16 | Coprocessor bus data |
| cop_wr | input | 1 | Coprocessor bus write flag |
| cfg_en | input | 4 | Per-comparator enable |
| cfg_bus | input | 4 | Per-comparator bus select (1 = coprocessor) |
| cfg_rwq | input | 4 | Per-comparator read/write qualifier enable |
| cfg_rwv | input | 4 | Required write flag when qualified |
| cfg_kind | input | 4 | Request type (1 = force, 0 = tag) |
| cfg_addr | input | 92 | Reference addresses, comparator i at [23i +: 23] |
| cfg_data | input | 32 | Data reference of pair p at [16p +: 16] |
| cfg_mask | input | 32 | Data mask of pair p at [16p +: 16] |
| cfg_mode | input | 4 | Pair mode, pair p at [2p +: 2] |
| exec_vld | input | 1 | Processor reports an instruction reaching execution |
| exec_addr | input | 23 | Address of that instruction |
| flush | input | 1 | Pipeline flush; drops pending tag requests |
| force_hit | output | 4 | Force request per comparator |
| tag_hit | output | 4 | Tag request per comparator |
| bkpt_req | output | 1 | Any breakpoint request |

## Verification
A bus access presented before a rising edge shows up on `force_hit` after that edge, one register stage later. A tag request shows up on `tag_hit` one stage after the rising edge that samples the matching execute report. The capturing access must lie at least one edge earlier than that report. The bench changes inputs on the falling edge and compares outputs on the next falling edge. Each check therefore looks at exactly the one register stage that follows the stimulus. The expected vectors come from a model written from the requirements, evaluated on the same inputs before the edge.

// File: rtl/bkw_pkg.sv
package bkw_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_INSIDE  = 2'd1,
    MODE_OUTSIDE = 2'd2,
    MODE_SINGLE2 = 2'd3
  } pair_mode_e;
endpackage

// File: rtl/bkw_cmp.sv
module bkw_cmp #(
  parameter int AW       = 23,
  parameter int DW       = 16,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic          cpu_vld,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          cpu_wr,
  input  logic          cop_vld,
  input  logic [AW-1:0] cop_addr,
  input  logic [DW-1:0] cop_data,
  input  logic          cop_wr,
  input  logic          en,
  input  logic          bus,
  input  logic          rwq,
  input  logic          rwv,
  input  logic [AW-1:0] ref_addr,
  input  logic [DW-1:0] ref_data,
  input  logic [DW-1:0] ref_mask,
  output logic          acc,
  output logic [AW-1:0] sel_addr,
  output logic          eq_hit
);
  logic          sel_vld;
  logic          sel_wr;
  logic [DW-1:0] sel_data;
  logic          data_ok;

  // pick the watched bus
  always_comb begin
    if (bus) begin
      sel_vld  = cop_vld;
      sel_addr = cop_addr;
      sel_data = cop_data;
      sel_wr   = cop_wr;
    end else begin
      sel_vld  = cpu_vld;
      sel_addr = cpu_addr;
      sel_data = cpu_data;
      sel_wr   = cpu_wr;
    end
  end

  assign acc = sel_vld & en & (~rwq | (sel_wr == rwv));

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = ((sel_data ^ ref_data) & ref_mask) == '0;
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{sel_data, ref_data, ref_mask};
      assign data_ok     = 1'b1;
    end
  endgenerate

  assign eq_hit = acc & (sel_addr == ref_addr) & data_ok;
endmodule

// File: rtl/bkw_pair.sv
module bkw_pair
  import bkw_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          cpu_vld,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          cpu_wr,
  input  logic          cop_vld,
  input  logic [AW-1:0] cop_addr,
  input  logic [DW-1:0] cop_data,
  input  logic          cop_wr,
  input  logic [1:0]    en,
  input  logic [1:0]    bus,
  input  logic [1:0]    rwq,
  input  logic [1:0]    rwv,
  input  logic [AW-1:0] ref_lo,
  input  logic [AW-1:0] ref_hi,
  input  logic [DW-1:0] ref_data,
  input  logic [DW-1:0] ref_mask,
  input  pair_mode_e    mode,
  output logic [1:0]    hit,
  output logic [2*AW-1:0] hit_addr
);
  logic          lo_acc, lo_eq, hi_eq, unused_hi_acc;
  logic [AW-1:0] lo_addr, hi_addr;

  bkw_cmp #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_lo (
    .cpu_vld(cpu_vld), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .cop_vld(cop_vld), .cop_addr(cop_addr), .cop_data(cop_data), .cop_wr(cop_wr),
    .en(en[0]), .bus(bus[0]), .rwq(rwq[0]), .rwv(rwv[0]),
    .ref_addr(ref_lo), .ref_data(ref_data), .ref_mask(ref_mask),
    .acc(lo_acc), .sel_addr(lo_addr), .eq_hit(lo_eq)
  );

  bkw_cmp #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_hi (
    .cpu_vld(cpu_vld), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .cop_vld(cop_vld), .cop_addr(cop_addr), .cop_data(cop_data), .cop_wr(cop_wr),
    .en(en[1]), .bus(bus[1]), .rwq(rwq[1]), .rwv(rwv[1]),
    .ref_addr(ref_hi), .ref_data('0), .ref_mask('0),
    .acc(unused_hi_acc), .sel_addr(hi_addr), .eq_hit(hi_eq)
  );

  // range modes use the low comparator's bus and qualifiers
  always_comb begin
    unique case (mode)
      MODE_INSIDE:  hit = {1'b0, lo_acc & (lo_addr >= ref_lo) & (lo_addr <= ref_hi)};
      MODE_OUTSIDE: hit = {1'b0, lo_acc & ((lo_addr < ref_lo) | (lo_addr > ref_hi))};
      default:      hit = {hi_eq, lo_eq};
    endcase
  end

  assign hit_addr = {hi_addr, lo_addr};
endmodule

// File: rtl/bkw_tag.sv
module bkw_tag #(
  parameter int NCMP = 4,
  parameter int AW   = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMP-1:0] arm,
  input  logic [NCMP*AW-1:0] arm_addr,
  input  logic            exec_vld,
  input  logic [AW-1:0]   exec_addr,
  input  logic            flush,
  output logic [NCMP-1:0] fire
);
  logic [NCMP-1:0] pend;
  logic [NCMP-1:0] fire_n;
  logic [AW-1:0]   paddr [NCMP];

  generate
    for (genvar i = 0; i < NCMP; i++) begin : g_slot
      assign fire_n[i] = exec_vld & ~flush & pend[i] & (paddr[i] == exec_addr);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend[i]  <= 1'b0;
          paddr[i] <= '0;
        end else if (arm[i]) begin
          pend[i]  <= 1'b1;
          paddr[i] <= arm_addr[i*AW +: AW];
        end else if (flush || fire_n[i]) begin
          pend[i]  <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire <= '0;
    else        fire <= fire_n;
  end

  // R11: a flush with no new capture leaves nothing pending
  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && arm == '0) |=> (pend == '0));

  // R10: a tag request only follows an execute report
  p_fire_needs_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |-> ($past(exec_vld) && !$past(flush)));

  // R10: a slot that fires was pending beforehand
  p_fire_from_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & ~$past(pend)) == '0);
endmodule

// File: rtl/bkpt_watch_unit.sv
module bkpt_watch_unit
  import bkw_pkg::*;
#(
  parameter int AW    = 23,
  parameter int DW    = 16,
  parameter int NPAIR = 2,
  localparam int NCMP = 2 * NPAIR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_vld,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_data,
  input  logic                cpu_wr,
  input  logic                cop_vld,
  input  logic [AW-1:0]       cop_addr,
  input  logic [DW-1:0]       cop_data,
  input  logic                cop_wr,
  input  logic [NCMP-1:0]     cfg_en,
  input  logic [NCMP-1:0]     cfg_bus,
  input  logic [NCMP-1:0]     cfg_rwq,
  input  logic [NCMP-1:0]     cfg_rwv,
  input  logic [NCMP-1:0]     cfg_kind,
  input  logic [NCMP*AW-1:0]  cfg_addr,
  input  logic [NPAIR*DW-1:0] cfg_data,
  input  logic [NPAIR*DW-1:0] cfg_mask,
  input  logic [2*NPAIR-1:0]  cfg_mode,
  input  logic                exec_vld,
  input  logic [AW-1:0]       exec_addr,
  input  logic                flush,
  output logic [NCMP-1:0]     force_hit,
  output logic [NCMP-1:0]     tag_hit,
  output logic                bkpt_req
);
  logic [NCMP-1:0]    hit;
  logic [NCMP*AW-1:0] hit_addr;

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      bkw_pair #(.AW(AW), .DW(DW)) u_pair (
        .cpu_vld(cpu_vld), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .cop_vld(cop_vld), .cop_addr(cop_addr), .cop_data(cop_data), .cop_wr(cop_wr),
        .en(cfg_en[2*p +: 2]), .bus(cfg_bus[2*p +: 2]),
        .rwq(cfg_rwq[2*p +: 2]), .rwv(cfg_rwv[2*p +: 2]),
        .ref_lo(cfg_addr[(2*p)*AW +: AW]), .ref_hi(cfg_addr[(2*p+1)*AW +: AW]),
        .ref_data(cfg_data[p*DW +: DW]), .ref_mask(cfg_mask[p*DW +: DW]),
        .mode(pair_mode_e'(cfg_mode[2*p +: 2])),
        .hit(hit[2*p +: 2]), .hit_addr(hit_addr[2*p*AW +: 2*AW])
      );

      // R7/R8: the high comparator stays silent in the range modes
      p_range_hi_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode[2*p +: 2]) == 2'd1 || $past(cfg_mode[2*p +: 2]) == 2'd2)
          |-> !force_hit[2*p+1]);

      // R5: a disabled comparator in single-match mode never forces
      p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cfg_en[2*p]) && ($past(cfg_mode[2*p +: 2]) == 2'd0 ||
                                 $past(cfg_mode[2*p +: 2]) == 2'd3))
          |-> !force_hit[2*p]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_hit <= '0;
    else        force_hit <= hit & cfg_kind;
  end

  bkw_tag #(.NCMP(NCMP), .AW(AW)) u_tag (
    .clk(clk), .rst_n(rst_n),
    .arm(hit & ~cfg_kind), .arm_addr(hit_addr),
    .exec_vld(exec_vld), .exec_addr(exec_addr), .flush(flush),
    .fire(tag_hit)
  );

  assign bkpt_req = (|force_hit) | (|tag_hit);

  // R9: a force request always follows a bus access
  p_force_after_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hit != '0) |-> ($past(cpu_vld) || $past(cop_vld)));

  // R9: force requests only on comparators set to force type
  p_force_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hit & ~$past(cfg_kind)) == '0);
endmodule

// File: tb/bkpt_watch_unit_test.sv
module bkpt_watch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cpu_vld = 0, cpu_wr = 0, cop_vld = 0, cop_wr = 0;
  logic [AW-1:0] cpu_addr = '0, cop_addr = '0, exec_addr = '0;
  logic [DW-1:0] cpu_data = '0, cop_data = '0;
  logic [3:0]    cfg_en = '0, cfg_bus = '0, cfg_rwq = '0, cfg_rwv = '0, cfg_kind = 4'hF;
  logic [3:0]    cfg_mode = '0;
  logic [AW-1:0] ref_a [4];
  logic [DW-1:0] dref [2];
  logic [DW-1:0] dmask [2];
  logic          exec_vld = 0, flush = 0;
  logic [4*AW-1:0] cfg_addr;
  logic [2*DW-1:0] cfg_data, cfg_mask;
  logic [3:0]    force_hit, tag_hit;
  logic          bkpt_req;

  always_comb begin
    cfg_addr = {ref_a[3], ref_a[2], ref_a[1], ref_a[0]};
    cfg_data = {dref[1], dref[0]};
    cfg_mask = {dmask[1], dmask[0]};
  end

  bkpt_watch_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_vld(cpu_vld), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .cop_vld(cop_vld), .cop_addr(cop_addr), .cop_data(cop_data), .cop_wr(cop_wr),
    .cfg_en(cfg_en), .cfg_bus(cfg_bus), .cfg_rwq(cfg_rwq), .cfg_rwv(cfg_rwv),
    .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask),
    .cfg_mode(cfg_mode), .exec_vld(exec_vld), .exec_addr(exec_addr), .flush(flush),
    .force_hit(force_hit), .tag_hit(tag_hit), .bkpt_req(bkpt_req)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // model of the match rules written from the requirements
  function automatic logic [3:0] model_hit();
    logic [3:0] h = '0;
    logic [3:0] q;
    logic [AW-1:0] a [4];
    logic [DW-1:0] d [4];
    for (int i = 0; i < 4; i++) begin
      logic v, w;
      v    = cfg_bus[i] ? cop_vld  : cpu_vld;
      w    = cfg_bus[i] ? cop_wr   : cpu_wr;
      a[i] = cfg_bus[i] ? cop_addr : cpu_addr;
      d[i] = cfg_bus[i] ? cop_data : cpu_data;
      q[i] = v && cfg_en[i] && (!cfg_rwq[i] || (w == cfg_rwv[i]));
    end
    for (int p = 0; p < 2; p++) begin
      int lo = 2*p;
      int hi = 2*p + 1;
      case (cfg_mode[2*p +: 2])
        2'd1: h[lo] = q[lo] && a[lo] >= ref_a[lo] && a[lo] <= ref_a[hi];
        2'd2: h[lo] = q[lo] && (a[lo] < ref_a[lo] || a[lo] > ref_a[hi]);
        default: begin
          h[lo] = q[lo] && a[lo] == ref_a[lo] && ((d[lo] ^ dref[p]) & dmask[p]) == '0;
          h[hi] = q[hi] && a[hi] == ref_a[hi];
        end
      endcase
    end
    return h;
  endfunction

  // inputs were set at a falling edge; compare after the next rising edge
  task automatic step_model(input string req);
    logic [3:0] h;
    h = model_hit() & cfg_kind;
    @(negedge clk);
    chk(req, force_hit, h);
    chk(req, tag_hit, 4'b0);
    chk("R12", {3'b0, bkpt_req}, {3'b0, |h});
  endtask

  task automatic step_tag(input string req, input logic [3:0] exp_tag);
    @(negedge clk);
    chk(req, tag_hit, exp_tag);
    chk(req, force_hit, 4'b0);
    chk("R12", {3'b0, bkpt_req}, {3'b0, |exp_tag});
  endtask

  task automatic idle();
    cpu_vld = 0; cop_vld = 0; exec_vld = 0; flush = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    ref_a[0] = 23'h7FFF00; ref_a[1] = 23'h001200;
    ref_a[2] = 23'h030000; ref_a[3] = 23'h400004;
    dref[0] = 16'hA5C3; dmask[0] = 16'hFF00;
    dref[1] = 16'h1234; dmask[1] = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", force_hit, 4'b0);
    chk("R1", tag_hit, 4'b0);
    chk("R1", {3'b0, bkpt_req}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing pending after reset
    cfg_en = 4'hF; cfg_kind = 4'h0;
    exec_vld = 1; exec_addr = ref_a[0];
    step_tag("R1", 4'b0);
    idle();
    cfg_kind = 4'hF;

    // R2 R3 R9: single-match sweep on the processor bus
    for (int i = 0; i < 4; i++)
      for (int off = -1; off <= 1; off++)
        for (int dp = 0; dp < 4; dp++)
          for (int w = 0; w < 2; w++) begin
            logic [DW-1:0] r, m;
            r = dref[i/2]; m = dmask[i/2];
            cpu_vld  = 1;
            cpu_addr = ref_a[i] + AW'(off);
            cpu_wr   = w[0];
            case (dp)
              0: cpu_data = r;
              1: cpu_data = r & m;
              2: cpu_data = r ^ 16'h0100;
              default: cpu_data = ~r;
            endcase
            step_model((i % 2) ? "R3 R9" : "R2 R9");
          end
    idle();

    // R4: bus selection, comparators 1 and 3 on the coprocessor bus
    cfg_bus = 4'b1010;
    for (int i = 0; i < 4; i++)
      for (int which = 0; which < 3; which++) begin
        cpu_vld = 1; cop_vld = 1;
        cpu_data = dref[i/2]; cop_data = dref[i/2];
        cpu_addr = (which != 1) ? ref_a[i] : 23'h7F0000;
        cop_addr = (which != 0) ? ref_a[i] : 23'h7F0000;
        step_model("R4");
      end
    idle();
    cfg_bus = 4'b0000;

    // R5 R6: enable and read/write qualifier sweep
    for (int en = 0; en < 16; en++)
      for (int rwc = 0; rwc < 4; rwc++)
        for (int i = 0; i < 4; i++)
          for (int w = 0; w < 2; w++) begin
            cfg_en  = 4'(en);
            cfg_rwq = {4{rwc[1]}};
            cfg_rwv = {4{rwc[0]}};
            cpu_vld = 1; cpu_addr = ref_a[i]; cpu_data = dref[i/2]; cpu_wr = w[0];
            step_model("R5 R6");
          end
    idle();
    cfg_en = 4'hF; cfg_rwq = '0; cfg_rwv = '0;

    // R7 R8: inside, outside and the second single-match code
    ref_a[0] = 23'h001000; ref_a[1] = 23'h001010;
    ref_a[2] = 23'h002000; ref_a[3] = 23'h002008;
    for (int md = 1; md < 4; md++)
      for (int b = 0; b < 2; b++)
        for (int off = -2; off <= 18; off++) begin
          cfg_mode = {2'(md), 2'(md)};
          cpu_vld  = 1;
          cpu_addr = (b == 0 ? 23'h001000 : 23'h002000) + AW'(off);
          cpu_data = 16'hFFFF;
          step_model(md == 3 ? "R8" : "R7 R8");
        end
    idle();
    cfg_mode = '0;

    // R10 R11: tag requests on comparator 0
    ref_a[0] = 23'h004444; ref_a[1] = 23'h7F0001;
    ref_a[2] = 23'h7F0002; ref_a[3] = 23'h7F0003;
    dmask[0] = 16'h0000;
    cfg_kind = 4'b1110;
    cpu_vld = 1; cpu_addr = 23'h004444;
    step_tag("R10", 4'b0);
    idle();
    exec_vld = 1; exec_addr = 23'h004445;
    step_tag("R10", 4'b0);
    exec_addr = 23'h004444;
    step_tag("R10", 4'b0001);
    step_tag("R10", 4'b0000);
    idle();
    // flush drops the pending request
    cpu_vld = 1; step_tag("R11", 4'b0); idle();
    flush = 1; step_tag("R11", 4'b0); idle();
    exec_vld = 1; step_tag("R11", 4'b0); idle();
    // execute in the same cycle as flush fires nothing
    cpu_vld = 1; step_tag("R11", 4'b0); idle();
    exec_vld = 1; flush = 1; step_tag("R11", 4'b0); idle();
    exec_vld = 1; step_tag("R11", 4'b0); idle();
    // a capture in the same cycle as flush survives
    cpu_vld = 1; flush = 1; step_tag("R11", 4'b0); idle();
    exec_vld = 1; step_tag("R11", 4'b0001); idle();
    step_tag("R10", 4'b0);

    finish_run();
  end
endmodule